// File: doc/BRIEF.md
# NRU Replacement Victim Selector

This block tracks two status bits for every page frame of a small physical memory: a use bit, set by any access to the frame, and a modified bit, set by writes. When the memory manager needs a frame to evict, it pulses a request. The block sorts the frames into four classes from their bits, takes the best non-empty class, and picks one frame of that class pseudo-randomly. The chosen index comes back one cycle later, together with a flag telling the manager that the frame holds dirty data that must be written out first.

The evicted frame is assumed to be refilled at once with the faulting page. Its bits are reloaded in the request cycle: use set, and modified set only when the faulting access was a write. A separate strobe, pulsed by a periodic timer outside the block, wipes all use bits at once and leaves the modified bits as they are. This lets recently idle frames drop back into cheaper classes.

The pseudo-random choice comes from a linear feedback shift register. It advances on every request, and its low bits give a starting frame. A wrapping scan from that frame returns the first member of the winning class.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every use bit and every modified bit is clear and `victim_valid` is low, so the first victim reported has `victim_wb` low.
- R2: A reference (`ref_valid` high) to frame `ref_idx` sets that frame's use bit at the next clock edge.
- R3: A reference with `ref_write` high also sets that frame's modified bit. A reference with `ref_write` low leaves the modified bit unchanged.
- R4: The class of a frame is the two-bit value {use, modified}, and lower values are preferred: 0 (unused, clean), then 1 (unused, modified), then 2 (used, clean), then 3 (used, modified).
- R5: The reported victim always belongs to the lowest class that holds any frame at the time of the request.
- R6: `victim_valid` is high in exactly the cycle after each cycle with `req` high, and low otherwise. `victim_idx` and `victim_wb` are valid while it is high.
- R7: `victim_wb` equals the victim's modified bit as it stood in the request cycle.
- R8: In the request cycle the victim's bits are reloaded: use set to 1, and modified set to `fill_write`.
- R9: A cycle with `clr_use` high clears every use bit and keeps every modified bit.
- R10: A reference or a refill in the same cycle as `clr_use` takes priority over the clear for the frame it targets, which ends that cycle with its use bit set.
- R11: The choice within a class is not fixed. Repeated requests with several equal candidates return more than one distinct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A frame is being accessed this cycle |
| ref_idx | input | IDX_W | Index of the accessed frame |
| ref_write | input | 1 | The access is a write |
| clr_use | input | 1 | Periodic strobe clearing all use bits |
| req | input | 1 | Request a replacement victim |
| fill_write | input | 1 | The faulting access that caused the request is a write |
| victim_valid | output | 1 | Victim result strobe, one cycle after `req` |
| victim_idx | output | IDX_W | Index of the chosen frame |
| victim_wb | output | 1 | The chosen frame is dirty and must be written back |

## Verification
A clear strobe can arrive in the same cycle as a reference, and a refill can land in the same cycle as a reference. The bench drives a clear together with a read reference to one frame. It then write-references every other frame, so that only the surviving frame is left in the used-clean class while all others are in the used-modified class. The next request must return that frame. A random sweep also mixes clears, references and requests. Every victim is judged against a bench model of both bit arrays that applies the reference-over-clear rule.

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int NFRAMES   = 8,
  parameter int LFSR_W    = 8,
  parameter int LFSR_SEED = 1,
  localparam int IDX_W    = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             ref_write,
  input  logic             clr_use,
  input  logic             req,
  input  logic             fill_write,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_wb
);
  logic [NFRAMES-1:0] use_q, mod_q, use_d, mod_d;
  logic [LFSR_W-1:0]  lfsr_q;
  logic [3:0]         occ;
  logic [1:0]         best;
  logic [IDX_W-1:0]   pick;
  int                 start;

  wire lfsr_fb = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-3] ^ lfsr_q[LFSR_W-4] ^ lfsr_q[LFSR_W-5];

  always_comb begin
    occ = '0;
    for (int i = 0; i < NFRAMES; i++) occ[{use_q[i], mod_q[i]}] = 1'b1;
  end

  assign best = occ[0] ? 2'd0 : occ[1] ? 2'd1 : occ[2] ? 2'd2 : 2'd3;
  assign start = int'(lfsr_q) % NFRAMES;

  always_comb begin
    logic found;
    int   j;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NFRAMES; k++) begin
      j = (start + k) % NFRAMES;
      if (!found && {use_q[j], mod_q[j]} == best) begin
        pick  = IDX_W'(j);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    use_d = use_q;
    mod_d = mod_q;
    if (clr_use) use_d = '0;
    if (req) begin
      use_d[pick] = 1'b1;
      mod_d[pick] = fill_write;
    end
    if (ref_valid) begin
      use_d[ref_idx] = 1'b1;
      if (ref_write) mod_d[ref_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q        <= '0;
      mod_q        <= '0;
      lfsr_q       <= LFSR_W'(LFSR_SEED);
      victim_valid <= 1'b0;
      victim_idx   <= '0;
      victim_wb    <= 1'b0;
    end else begin
      use_q        <= use_d;
      mod_q        <= mod_d;
      victim_valid <= req;
      if (req) begin
        lfsr_q     <= {lfsr_q[LFSR_W-2:0], lfsr_fb};
        victim_idx <= pick;
        victim_wb  <= mod_q[pick];
      end
    end
  end
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
  parameter int NFRAMES = 8,
  parameter int IDX_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_valid,
  input logic [IDX_W-1:0] ref_idx,
  input logic             ref_write,
  input logic             clr_use,
  input logic             req,
  input logic             victim_valid,
  input logic [IDX_W-1:0] victim_idx,
  input logic             victim_wb,
  input logic [NFRAMES-1:0] use_q,
  input logic [NFRAMES-1:0] mod_q
);
  logic [NFRAMES-1:0] use_prev, mod_prev;
  logic               lower_exists;

  always_ff @(posedge clk) begin
    use_prev <= use_q;
    mod_prev <= mod_q;
  end

  always_comb begin
    lower_exists = 1'b0;
    for (int i = 0; i < NFRAMES; i++)
      if ({use_prev[i], mod_prev[i]} < {use_prev[victim_idx], mod_prev[victim_idx]})
        lower_exists = 1'b1;
  end

  p_ref_sets_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> use_q[$past(ref_idx)]);
  p_write_sets_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_write) |=> mod_q[$past(ref_idx)]);
  p_lowest_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !lower_exists);
  p_strobe_after_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> victim_valid);
  p_no_spurious_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !victim_valid);
  p_wb_from_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> victim_wb == mod_prev[victim_idx]);
  p_clear_keeps_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_use && !ref_valid && !req) |=> (use_q == '0) && (mod_q == $past(mod_q)));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/nru_victim_sel_bench.sv
module nru_victim_sel_bench;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_valid = 0, ref_write = 0, clr_use = 0, req = 0, fill_write = 0;
  logic [IW-1:0] ref_idx = '0;
  logic victim_valid, victim_wb;
  logic [IW-1:0] victim_idx;

  int checks = 0, fails = 0;
  bit [N-1:0] mu, mm;
  int last_v;

  always #10 clk = ~clk;

  nru_victim_sel #(.NFRAMES(N)) u_nru_victim_sel (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    mu = '0; mm = '0;
  endtask

  task automatic do_ref(int idx, bit wr);
    ref_valid = 1; ref_idx = IW'(idx); ref_write = wr;
    @(negedge clk);
    ref_valid = 0; ref_write = 0;
    mu[idx] = 1; if (wr) mm[idx] = 1;
  endtask

  task automatic do_clear(bit with_ref, int idx);
    clr_use = 1; ref_valid = with_ref; ref_idx = IW'(idx); ref_write = 0;
    @(negedge clk);
    clr_use = 0; ref_valid = 0;
    mu = '0; if (with_ref) mu[idx] = 1;
  endtask

  task automatic do_req(bit fw, string tag);
    int minc;
    minc = 3;
    for (int i = 0; i < N; i++) if (int'({mu[i], mm[i]}) < minc) minc = int'({mu[i], mm[i]});
    req = 1; fill_write = fw;
    @(negedge clk);
    req = 0; fill_write = 0;
    last_v = int'(victim_idx);
    check({"R6 strobe ", tag}, int'(victim_valid), 1);
    check({"R5 class ", tag}, int'({mu[last_v], mm[last_v]}), minc);
    check({"R7 wb ", tag}, int'(victim_wb), int'(mm[last_v]));
    mu[last_v] = 1; mm[last_v] = fw;
    @(negedge clk);
    check({"R6 single ", tag}, int'(victim_valid), 0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit [N-1:0] seen;
    int distinct;
    do_reset();
    check("R1 valid after reset", int'(victim_valid), 0);
    do_req(0, "R1 first");
    check("R1 clean first victim", int'(victim_wb), 0);

    // R4 each class in turn
    do_reset();
    for (int i = 0; i < N; i++) do_ref(i, i < 4);
    do_req(0, "R4 used-clean");
    do_clear(0, 0);
    do_req(0, "R4 unused-clean");
    do_reset();
    for (int i = 0; i < N; i++) do_ref(i, 1);
    do_clear(0, 0);
    do_req(0, "R4 unused-mod");
    do_reset();
    for (int i = 0; i < N; i++) do_ref(i, 1);
    do_req(1, "R4 used-mod");
    check("R2 R3 all dirty wb", int'(victim_wb), 1);

    // R8 refill with write
    do_reset();
    do_req(1, "R8 fill");
    begin
      int a;
      a = last_v;
      do_clear(0, 0);
      for (int i = 0; i < N; i++) if (i != a) do_ref(i, 1);
      do_req(0, "R8 reuse");
      check("R8 refilled frame chosen", last_v, a);
      check("R8 refilled frame dirty", int'(victim_wb), 1);
    end

    // R9 clear keeps modified
    do_reset();
    do_ref(2, 1);
    do_clear(0, 0);
    for (int i = 0; i < N; i++) if (i != 2) do_ref(i, 0);
    do_req(0, "R9");
    check("R9 modified kept", last_v, 2);
    check("R9 wb", int'(victim_wb), 1);

    // R10 reference beats clear
    do_reset();
    for (int i = 0; i < N; i++) do_ref(i, 0);
    do_clear(1, 5);
    for (int i = 0; i < N; i++) if (i != 5) do_ref(i, 1);
    do_req(0, "R10");
    check("R10 ref over clear", last_v, 5);
    check("R3 read keeps clean", int'(victim_wb), 0);

    // R11 varied choice
    do_reset();
    seen = '0;
    for (int r = 0; r < 12; r++) begin
      do_req(0, "R11");
      seen[last_v] = 1;
      do_clear(0, 0);
    end
    distinct = $countones(seen);
    checks++;
    if (distinct < 2) begin
      fails++;
      $display("FAIL R11 actual=%0d expected>=2", distinct);
    end

    // random mixed sweep
    do_reset();
    for (int s = 0; s < 600; s++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 5) do_ref(int'($urandom_range(0, N - 1)), 1'($urandom_range(0, 1)));
      else if (op < 6) do_clear(1'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)));
      else do_req(1'($urandom_range(0, 1)), "sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule